// File: doc/BRIEF.md
# Pipelined Polar-to-Cartesian Converter

This block turns a polar pair (an unsigned 16-bit radius and a 16-bit angle) into a Cartesian pair (16-bit X and 16-bit Y). It accepts one pair on every clock and returns one pair on every clock. The angle word covers a full turn modulo 2π. One LSB weighs π/32768 radians, so 16'h4000 is a quarter turn and 16'h8000 is a half turn. A wider upstream phase word is connected by its sixteen most significant bits. The rotation uses shift-and-add stages. The radius is scaled by the inverse of the rotation gain before the first stage, so the result comes out with unit gain.

A format select travels with each sample and sets how the two Cartesian words are coded. It picks either two's complement or sign-and-magnitude. A 16-bit radius can describe a point whose components do not fit in 16 signed bits. In that case the block does not saturate. Each output word keeps the low bits of the rounded component, and a flag marks that pair as out of range. The flag is computed from the rounded full-width component. Because the two formats reach different negative limits, the flag behaves differently in each.

Top module: `p2r_converter`

## Requirements
- R1: A pair presented before rising edge n appears on the outputs after rising edge n+21 (22 clocks of latency), and a new pair is accepted on every edge.
- R2: While rst_n is low, and after reset until a sample has passed through, x_out and y_out are 16'h0000 and ovf is low.
- R3: At angle words 16'h0000, 16'h4000, 16'h8000 and 16'hC000 (0, π/2, π and -π/2), the rounded components equal ±radius and 0 exactly.
- R4: At any other angle, each rounded component is within 1 LSB of round(radius·cos θ) or round(radius·sin θ), with θ = π·angle/32768.
- R5: With fmt_tc high, each output word is the low 16 bits of the two's complement rounded component.
- R6: With fmt_tc low, bit 15 is set only for a negative component and bits 14:0 hold the low 15 bits of its magnitude. Zero is 16'h0000, so 16'h8000 never appears on an in-range output.
- R7: In two's complement, ovf is high when either rounded component is above 32767 or below -32768. A component of -32768 is in range.
- R8: In sign-and-magnitude, ovf is high when either rounded component has a magnitude of 32768 or more.
- R9: A radius of 32767 or less never raises ovf, at any angle and in either format.
- R10: A radius of 46343 or more raises ovf at every angle in both formats.
- R11: ovf describes the pair it is output with. It falls on the first output pair that fits.
- R12: The fmt_tc value sampled together with a pair sets the coding of that pair, so changing fmt_tc on every clock keeps each result consistent.
- R13: A radius of zero gives 16'h0000 on both outputs with ovf low, at every angle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of all pipeline registers |
| radius | input | 16 | Unsigned radius |
| phase | input | 16 | Angle word, LSB = π/32768 rad, modulo 2π |
| fmt_tc | input | 1 | 1 = two's complement outputs, 0 = sign-and-magnitude |
| x_out | output | 16 | Cartesian X in the selected format |
| y_out | output | 16 | Cartesian Y in the selected format |
| ovf | output | 1 | High when this output pair did not fit its format |

## Verification
The checker follows each sample's radius and format down a 22-deep shadow line and tests the result on every cycle. It confirms that a radius at or below 32767 never flags, and that one at or above 46343 always flags. It also confirms that a zero radius gives two zero words, and that an in-range sign-and-magnitude word is never a negative zero. The exact wrapped low-bit patterns, the asymmetric -32768 limit in two's complement, and the arithmetic accuracy all need known expected values. So do the precise latency count and the per-sample format switching. Only the bench's directed scenarios can show these, by comparing the outputs with values computed from trigonometry.

// File: rtl/p2r_pkg.sv
package p2r_pkg;

    // Port width of radius, angle and each Cartesian word
    localparam int IO_W      = 16;
    // Fraction bits carried through the rotation stages
    localparam int GUARD     = 12;
    // Rotation datapath width: sign, 17 integer bits, guard fraction
    localparam int DW        = 18 + GUARD;
    // Residual angle kept in radians with ZF fraction bits
    localparam int ZF        = 28;
    localparam int ZW        = 32;
    // pi scaled by 2^ZF
    localparam longint PI_Q  = 64'sd843314857;
    // Reciprocal of the rotation gain, scaled by 2^GAIN_FRAC
    localparam int GAIN_FRAC = 24;
    localparam longint INV_GAIN = 64'sd10188014;

    typedef struct packed {
        logic signed [DW-1:0] x;
        logic signed [DW-1:0] y;
        logic signed [ZW-1:0] z;
        logic                 tc;
    } rot_t;

    // arctan(2^-idx) in radians, scaled by 2^ZF, from its odd power series
    function automatic longint atan_step(input int idx);
        longint acc;
        longint term;
        if (idx == 0) begin
            return PI_Q / 4;
        end
        acc = 0;
        for (int k = 0; k < 31; k++) begin
            int sh;
            sh = idx * (2 * k + 1);
            if (sh < 61) begin
                term = (longint'(1) <<< (60 - sh)) / longint'(2 * k + 1);
                if (k % 2 == 0) begin
                    acc = acc + term;
                end else begin
                    acc = acc - term;
                end
            end
        end
        return acc >>> (60 - ZF);
    endfunction

endpackage

// File: rtl/p2r_front.sv
module p2r_front
    import p2r_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IO_W-1:0] radius,
    input  logic [IO_W-1:0] phase,
    input  logic            fmt_tc,
    output rot_t            seed
);

    localparam int QSH = IO_W - 2;

    logic [IO_W-1:0] rad_q;
    logic [IO_W-1:0] ph_q;
    logic            tc_q;

    // Stage 1: capture the sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rad_q <= '0;
            ph_q  <= '0;
            tc_q  <= 1'b0;
        end else begin
            rad_q <= radius;
            ph_q  <= phase;
            tc_q  <= fmt_tc;
        end
    end

    logic [1:0]           quad;
    logic [IO_W-1:0]      resid;
    longint               zfull;
    longint               sfull;
    logic signed [DW-1:0] mag;
    rot_t                 seed_d;

    // Stage 2: fold to the nearest quarter turn, convert the residual to
    // radians, pre-divide the radius by the rotation gain
    always_comb begin
        quad  = ph_q[IO_W-1 -: 2] + {1'b0, ph_q[QSH-1]};
        resid = ph_q - {quad, {QSH{1'b0}}};
        zfull = (longint'(signed'(resid)) * PI_Q) >>> (IO_W - 1);
        sfull = longint'(rad_q) * INV_GAIN;
        mag   = signed'(DW'(sfull >>> (GAIN_FRAC - GUARD)));
        seed_d.z  = ZW'(zfull);
        seed_d.tc = tc_q;
        unique case (quad)
            2'd0: begin seed_d.x = mag;  seed_d.y = '0;   end
            2'd1: begin seed_d.x = '0;   seed_d.y = mag;  end
            2'd2: begin seed_d.x = -mag; seed_d.y = '0;   end
            2'd3: begin seed_d.x = '0;   seed_d.y = -mag; end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seed <= '0;
        end else begin
            seed <= seed_d;
        end
    end

endmodule

// File: rtl/p2r_rot_stage.sv
module p2r_rot_stage
    import p2r_pkg::*;
#(
    parameter int IDX = 0
)
(
    input  logic clk,
    input  logic rst_n,
    input  rot_t d,
    output rot_t q
);

    localparam logic signed [ZW-1:0] ANG = ZW'(atan_step(IDX));

    rot_t nxt;

    // Turn toward a zero residual angle by arctan(2^-IDX)
    always_comb begin
        nxt.tc = d.tc;
        if (!d.z[ZW-1]) begin
            nxt.x = d.x - (d.y >>> IDX);
            nxt.y = d.y + (d.x >>> IDX);
            nxt.z = d.z - ANG;
        end else begin
            nxt.x = d.x + (d.y >>> IDX);
            nxt.y = d.y - (d.x >>> IDX);
            nxt.z = d.z + ANG;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/p2r_format.sv
module p2r_format
    import p2r_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  rot_t            d,
    output logic [IO_W-1:0] x_out,
    output logic [IO_W-1:0] y_out,
    output logic            ovf
);

    localparam int IW   = DW - GUARD;
    localparam int MAXP = 2 ** (IO_W - 1) - 1;

    function automatic logic signed [IW-1:0] round_near(input logic signed [DW-1:0] v);
        logic signed [DW-1:0] t;
        t = v + DW'(1 <<< (GUARD - 1));
        return IW'(t >>> GUARD);
    endfunction

    function automatic logic fits(input logic signed [IW-1:0] v, input logic tc);
        return (v <= MAXP) && (tc ? (v >= -MAXP - 1) : (v >= -MAXP));
    endfunction

    function automatic logic [IO_W-1:0] encode(input logic signed [IW-1:0] v, input logic tc);
        logic [IW-1:0] m;
        m = v[IW-1] ? IW'(-v) : IW'(v);
        if (tc) begin
            return IO_W'(v);
        end
        return {v[IW-1], (IO_W - 1)'(m)};
    endfunction

    logic signed [IW-1:0] xr;
    logic signed [IW-1:0] yr;

    always_comb begin
        xr = round_near(d.x);
        yr = round_near(d.y);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_out <= '0;
            y_out <= '0;
            ovf   <= 1'b0;
        end else begin
            x_out <= encode(xr, d.tc);
            y_out <= encode(yr, d.tc);
            ovf   <= !(fits(xr, d.tc) && fits(yr, d.tc));
        end
    end

endmodule

// File: rtl/p2r_converter.sv
module p2r_converter
    import p2r_pkg::*;
#(
    parameter int ITERS = 19
)
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IO_W-1:0] radius,
    input  logic [IO_W-1:0] phase,
    input  logic            fmt_tc,
    output logic [IO_W-1:0] x_out,
    output logic [IO_W-1:0] y_out,
    output logic            ovf
);

    rot_t pipe [ITERS+1];

    p2r_front u_front (
        .clk    (clk),
        .rst_n  (rst_n),
        .radius (radius),
        .phase  (phase),
        .fmt_tc (fmt_tc),
        .seed   (pipe[0])
    );

    for (genvar i = 0; i < ITERS; i++) begin : g_rot
        p2r_rot_stage #(.IDX(i)) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (pipe[i]),
            .q     (pipe[i+1])
        );
    end

    p2r_format u_format (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pipe[ITERS]),
        .x_out (x_out),
        .y_out (y_out),
        .ovf   (ovf)
    );

endmodule

// File: rtl/p2r_converter_chk.sv
module p2r_converter_chk #(
    parameter int LAT = 22
)
(
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] radius,
    input logic        fmt_tc,
    input logic [15:0] x_out,
    input logic [15:0] y_out,
    input logic        ovf
);

    logic [LAT-1:0] small_sr;
    logic [LAT-1:0] big_sr;
    logic [LAT-1:0] zero_sr;
    logic [LAT-1:0] sm_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            small_sr <= '1;
            big_sr   <= '0;
            zero_sr  <= '1;
            sm_sr    <= '0;
        end else begin
            small_sr <= {small_sr[LAT-2:0], radius <= 16'd32767};
            big_sr   <= {big_sr[LAT-2:0],   radius >= 16'd46343};
            zero_sr  <= {zero_sr[LAT-2:0],  radius == 16'd0};
            sm_sr    <= {sm_sr[LAT-2:0],    !fmt_tc};
        end
    end

    // R9
    small_radius_chk: assert property (@(posedge clk) disable iff (!rst_n)
        small_sr[LAT-1] |-> !ovf);

    // R10
    large_radius_chk: assert property (@(posedge clk) disable iff (!rst_n)
        big_sr[LAT-1] |-> ovf);

    // R13 (the reset pipeline reads as radius zero, covering R2)
    zero_radius_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_sr[LAT-1] |-> (x_out == 16'h0000 && y_out == 16'h0000 && !ovf));

    // R6
    sm_negzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sm_sr[LAT-1] && !ovf) |-> (x_out != 16'h8000 && y_out != 16'h8000));

endmodule

bind p2r_converter p2r_converter_chk #(.LAT(ITERS + 3)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .radius (radius),
    .fmt_tc (fmt_tc),
    .x_out  (x_out),
    .y_out  (y_out),
    .ovf    (ovf)
);

// File: tb/p2r_converter_bench.sv
module p2r_converter_bench;

    localparam int LAT = 22;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] radius = '0;
    logic [15:0] phase = '0;
    logic        fmt_tc = 1'b0;
    logic [15:0] x_out;
    logic [15:0] y_out;
    logic        ovf;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    p2r_converter u_p2r_converter (.*);

    function automatic int ideal(input int r, input int ph, input bit want_y);
        real a;
        real v;
        a = 3.14159265358979 * $itor(ph) / 32768.0;
        v = want_y ? $itor(r) * $sin(a) : $itor(r) * $cos(a);
        return $rtoi($floor(v + 0.5));
    endfunction

    function automatic logic [15:0] enc(input int v, input bit tc);
        int m;
        m = (v < 0) ? -v : v;
        if (tc) return v[15:0];
        return {(v < 0) ? 1'b1 : 1'b0, m[14:0]};
    endfunction

    function automatic bit fit(input int v, input bit tc);
        return tc ? (v >= -32768 && v <= 32767) : (v >= -32767 && v <= 32767);
    endfunction

    function automatic bit near(input logic [15:0] got, input int e, input bit tc, input int tol);
        for (int d = -tol; d <= tol; d++) begin
            if (got == enc(e + d, tc)) return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic check_pair(input string tag, input int r, input int ph, input bit tc, input int tol);
        int  ex;
        int  ey;
        bit  eo;
        ex = ideal(r, ph, 1'b0);
        ey = ideal(r, ph, 1'b1);
        eo = !(fit(ex, tc) && fit(ey, tc));
        checks++;
        if (!near(x_out, ex, tc, tol) || !near(y_out, ey, tc, tol) || ovf !== eo) begin
            errors++;
            $display("FAIL %s r=%0d ph=%h tc=%0d: got x=%h y=%h ovf=%b expected x=%h y=%h ovf=%b (tol %0d)",
                     tag, r, ph[15:0], tc, x_out, y_out, ovf, enc(ex, tc), enc(ey, tc), eo, tol);
        end
    endtask

    task automatic check_raw(input string tag, input logic [15:0] ex, input logic [15:0] ey, input bit eo);
        checks++;
        if (x_out !== ex || y_out !== ey || ovf !== eo) begin
            errors++;
            $display("FAIL %s: got x=%h y=%h ovf=%b expected x=%h y=%h ovf=%b",
                     tag, x_out, y_out, ovf, ex, ey, eo);
        end
    endtask

    task automatic one(input string tag, input int r, input int ph, input bit tc, input int tol);
        @(negedge clk);
        radius = r[15:0];
        phase  = ph[15:0];
        fmt_tc = tc;
        repeat (LAT) @(negedge clk);
        check_pair(tag, r, ph, tc, tol);
    endtask

    // R2
    task automatic t_reset();
        repeat (3) @(negedge clk);
        check_raw("R2 during reset", 16'h0000, 16'h0000, 1'b0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_raw("R2 after release", 16'h0000, 16'h0000, 1'b0);
    endtask

    // R1: a single pulse appears after exactly 22 clocks, not before or after
    task automatic t_latency();
        @(negedge clk);
        radius = 16'd20000; phase = 16'h0000; fmt_tc = 1'b1;
        @(negedge clk);
        radius = 16'd0;
        repeat (LAT - 2) @(negedge clk);
        check_raw("R1 one clock early", 16'h0000, 16'h0000, 1'b0);
        @(negedge clk);
        check_raw("R1 at latency", 16'h4E20, 16'h0000, 1'b0);
        @(negedge clk);
        check_raw("R1 one clock late", 16'h0000, 16'h0000, 1'b0);
    endtask

    // R3, R5, R6: exact axis results in both codings
    task automatic t_axes();
        for (int tc = 0; tc < 2; tc++) begin
            for (int q = 0; q < 4; q++) begin
                one("R3/R5/R6 axis", 20000, q * 16'h4000, tc[0], 0);
            end
        end
    endtask

    // R4: general angles within 1 LSB
    task automatic t_general();
        int rs[4] = '{12345, 30000, 25000, 5};
        int ps[4] = '{16'h1555, 16'h6000, 16'hB333, 16'h7000};
        for (int i = 0; i < 4; i++) begin
            one("R4 general tc", rs[i], ps[i], 1'b1, 1);
            one("R4 general sm", rs[i], ps[i], 1'b0, 1);
        end
    endtask

    // R5, R6, R7, R8: wraparound to low bits and the asymmetric limit
    task automatic t_wrap();
        one("R8 sm +32768 wraps to 0000", 32768, 16'h0000, 1'b0, 0);
        one("R7 tc +32768 wraps to 8000", 32768, 16'h0000, 1'b1, 0);
        one("R7 tc -32768 is legal",      32768, 16'h8000, 1'b1, 0);
        one("R8 sm -32768 overflows",     32768, 16'h8000, 1'b0, 0);
        one("R6 sm 65535 at 0",           65535, 16'h0000, 1'b0, 0);
        one("R5 tc 65535 at 0",           65535, 16'h0000, 1'b1, 0);
        one("R6 sm 65535 at pi",          65535, 16'h8000, 1'b0, 0);
        one("R5 tc 65535 at pi",          65535, 16'h8000, 1'b1, 0);
        one("R7 tc y +32768",             32768, 16'h4000, 1'b1, 0);
        one("R7 tc y -32768 legal",       32768, 16'hC000, 1'b1, 0);
    endtask

    // R9, R10: radius limits
    task automatic t_limits();
        for (int tc = 0; tc < 2; tc++) begin
            for (int k = 0; k < 8; k++) begin
                one("R9 radius 32767", 32767, k * 16'h2000, tc[0], 1);
            end
            for (int k = 0; k < 4; k++) begin
                one("R10 radius 46343", 46343, 16'h2000 + k * 16'h4000, tc[0], 1);
            end
        end
    endtask

    // R1, R11, R12, R13: back-to-back stream with format flipping
    task automatic t_stream();
        int rs[8] = '{32768, 32767, 32768, 32768, 0, 32768, 1000, 46343};
        int ps[8] = '{16'h0000, 16'h0000, 16'h8000, 16'h8000, 16'h1234, 16'h4000, 16'h1000, 16'h2000};
        bit ts[8] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
        int tl[8] = '{0, 0, 0, 0, 0, 0, 1, 1};
        for (int j = 0; j < 8 + LAT; j++) begin
            @(negedge clk);
            if (j >= LAT) begin
                check_pair("R11/R12/R13 stream", rs[j-LAT], ps[j-LAT], ts[j-LAT], tl[j-LAT]);
            end
            if (j < 8) begin
                radius = rs[j][15:0];
                phase  = ps[j][15:0];
                fmt_tc = ts[j];
            end else begin
                radius = 16'd0;
            end
        end
    endtask

    initial begin
        t_reset();
        t_latency();
        t_axes();
        t_general();
        t_wrap();
        t_limits();
        t_stream();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule